// File: doc/BRIEF.md
# Wrapping Decade Down Counter with Overflow Tail

This block is a synchronous state machine whose 4-bit state is the output. On each enabled clock edge it counts down from nine to zero. After zero it climbs through a short tail of ten, eleven and twelve, then returns to nine and repeats. The full cycle is thirteen states long. The three encodings that are never part of the cycle (thirteen, fourteen and fifteen) are treated as corruption. Whichever of them the state holds, it goes back to nine on the very next edge, with or without enable.

A synchronous reset restarts the count at nine. A test-only load path lets a bench or a scan-style harness place any value in the state register, including the illegal ones, so that the recovery logic can be exercised. The restart value and the last value of the tail are parameters. With the defaults they give the 9-down-to-0, then 10-to-12 cycle.

Top module: `seq_down_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `cnt_o` is 9 after that edge, whatever `cnt_en`, `tst_ld` and `tst_val` are.
- R2: With `cnt_en` high and the state in 1..9, the next state is the present state minus one.
- R3: With `cnt_en` high, state 0 is followed by 10, 10 by 11, and 11 by 12.
- R4: With `cnt_en` high and the state at 12, the next state is 9.
- R5: A state of 13, 14 or 15 becomes 9 after one rising edge, whether `cnt_en` is high or low (unless `rst` or `tst_ld` is high).
- R6: With `cnt_en` low and a legal state (0..12), the state holds its value.
- R7: When `tst_ld` is high and `rst` is low, the state takes `tst_val` after the edge. This overrides counting, holding and illegal-state recovery.
- R8: Starting from 9, thirteen enabled edges bring the state back to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to the restart value |
| cnt_en | input | 1 | Advance one step of the sequence when high |
| tst_ld | input | 1 | Test-only load strobe |
| tst_val | input | 4 | Value written by the test-only load |
| cnt_o | output | 4 | Present state of the counter |

## Verification
The bench builds the counter with its default parameters: restart value 9 and tail end 12. With these values the 4-bit width leaves exactly three unused codes above the tail. That makes it possible to load each of 13, 14 and 15 through the test port and to watch each one recover, once with enable high and once with enable low. The same defaults make the whole 13-state loop short enough to walk end to end several times. The walk covers both wrap points: zero into the tail, and twelve back to nine.

// File: rtl/seq_ctr_pkg.sv
package seq_ctr_pkg;

    localparam int CNT_W = 4;

    typedef enum logic [2:0] {
        RGN_ZERO = 3'd0,
        RGN_DOWN = 3'd1,
        RGN_TAIL = 3'd2,
        RGN_LAST = 3'd3,
        RGN_BAD  = 3'd4
    } region_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;

endpackage

// File: rtl/seq_region_classify.sv
module seq_region_classify
    import seq_ctr_pkg::*;
#(
    parameter int SEED_VAL = 9,
    parameter int LAST_VAL = 12
) (
    input  logic [CNT_W-1:0] cur_i,
    output region_e          rgn_o
);

    localparam logic [CNT_W-1:0] SEED_C = CNT_W'(SEED_VAL);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LAST_VAL);

    always_comb begin
        if (cur_i == '0) begin
            rgn_o = RGN_ZERO;
        end else if (cur_i <= SEED_C) begin
            rgn_o = RGN_DOWN;
        end else if (cur_i < LAST_C) begin
            rgn_o = RGN_TAIL;
        end else if (cur_i == LAST_C) begin
            rgn_o = RGN_LAST;
        end else begin
            rgn_o = RGN_BAD;
        end
    end

endmodule

// File: rtl/seq_step_logic.sv
module seq_step_logic
    import seq_ctr_pkg::*;
#(
    parameter int SEED_VAL = 9
) (
    input  logic [CNT_W-1:0] cur_i,
    input  region_e          rgn_i,
    input  logic             en_i,
    output logic [CNT_W-1:0] nxt_o
);

    localparam logic [CNT_W-1:0] SEED_C  = CNT_W'(SEED_VAL);
    localparam logic [CNT_W-1:0] ENTRY_C = CNT_W'(SEED_VAL + 1);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    always_comb begin
        nxt_o = cur_i;
        unique case (rgn_i)
            RGN_BAD:  nxt_o = SEED_C;
            RGN_ZERO: if (en_i) nxt_o = ENTRY_C;
            RGN_DOWN: if (en_i) nxt_o = cur_i - ONE_C;
            RGN_TAIL: if (en_i) nxt_o = cur_i + ONE_C;
            RGN_LAST: if (en_i) nxt_o = SEED_C;
            default:  nxt_o = SEED_C;
        endcase
    end

endmodule

// File: rtl/seq_down_counter.sv
module seq_down_counter
    import seq_ctr_pkg::*;
#(
    parameter int SEED_VAL = 9,
    parameter int LAST_VAL = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             tst_ld,
    input  logic [CNT_W-1:0] tst_val,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] SEED_C = CNT_W'(SEED_VAL);

    ctr_state_t       st_d;
    ctr_state_t       st_q;
    region_e          rgn;
    logic [CNT_W-1:0] step_nxt;

    seq_region_classify #(
        .SEED_VAL (SEED_VAL),
        .LAST_VAL (LAST_VAL)
    ) u_classify (
        .cur_i (st_q.cnt),
        .rgn_o (rgn)
    );

    seq_step_logic #(
        .SEED_VAL (SEED_VAL)
    ) u_step (
        .cur_i (st_q.cnt),
        .rgn_i (rgn),
        .en_i  (cnt_en),
        .nxt_o (step_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cnt = SEED_C;
        end else if (tst_ld) begin
            st_d.cnt = tst_val;
        end else begin
            st_d.cnt = step_nxt;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/seq_down_counter_chk.sv
module seq_down_counter_chk
    import seq_ctr_pkg::*;
#(
    parameter int SEED_VAL = 9,
    parameter int LAST_VAL = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_en,
    input logic             tst_ld,
    input logic [CNT_W-1:0] tst_val,
    input logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] SEED_C  = CNT_W'(SEED_VAL);
    localparam logic [CNT_W-1:0] ENTRY_C = CNT_W'(SEED_VAL + 1);
    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(LAST_VAL);

    logic rst_prev_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_prev_q <= rst;
        if (rst_prev_q) begin
            a_r1_reset_to_seed: assert (cnt_o == SEED_C);
        end
    end

    wire free_run = !tst_ld;

    a_r2_step_down: assert property (@(posedge clk) disable iff (rst)
        (free_run && cnt_en && cnt_o != '0 && cnt_o <= SEED_C)
        |=> (cnt_o == $past(cnt_o) - CNT_W'(1)));

    a_r3_zero_to_tail: assert property (@(posedge clk) disable iff (rst)
        (free_run && cnt_en && cnt_o == '0) |=> (cnt_o == ENTRY_C));

    a_r3_tail_climb: assert property (@(posedge clk) disable iff (rst)
        (free_run && cnt_en && cnt_o > SEED_C && cnt_o < LAST_C)
        |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

    a_r4_last_wraps: assert property (@(posedge clk) disable iff (rst)
        (free_run && cnt_en && cnt_o == LAST_C) |=> (cnt_o == SEED_C));

    a_r5_bad_recovers: assert property (@(posedge clk) disable iff (rst)
        (free_run && cnt_o > LAST_C) |=> (cnt_o == SEED_C));

    a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (free_run && !cnt_en && cnt_o <= LAST_C) |=> $stable(cnt_o));

    a_r7_test_load: assert property (@(posedge clk) disable iff (rst)
        tst_ld |=> (cnt_o == $past(tst_val)));

endmodule

bind seq_down_counter seq_down_counter_chk #(
    .SEED_VAL (SEED_VAL),
    .LAST_VAL (LAST_VAL)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cnt_en  (cnt_en),
    .tst_ld  (tst_ld),
    .tst_val (tst_val),
    .cnt_o   (cnt_o)
);

// File: tb/tb_seq_down_counter.sv
module tb_seq_down_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic       tst_ld = 1'b0;
    logic [3:0] tst_val = 4'd0;
    logic [3:0] cnt_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit reported = 1'b0;

    logic [3:0] exp_q[$];
    string      tag_q[$];
    logic [3:0] model_st = 4'd0;

    always #5 clk = ~clk;

    seq_down_counter dut (
        .clk     (clk),
        .rst     (rst),
        .cnt_en  (cnt_en),
        .tst_ld  (tst_ld),
        .tst_val (tst_val),
        .cnt_o   (cnt_o)
    );

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: cnt_o=%0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the predicted result.
    task automatic drive(input bit r, input bit e, input bit l, input logic [3:0] v);
        logic [3:0] nxt;
        string      tag;
        @(negedge clk);
        rst = r; cnt_en = e; tst_ld = l; tst_val = v;
        if (r) begin
            nxt = 4'd9; tag = "R1";
        end else if (l) begin
            nxt = v; tag = "R7";
        end else if (model_st > 4'd12) begin
            nxt = 4'd9; tag = "R5";
        end else if (!e) begin
            nxt = model_st; tag = "R6";
        end else if (model_st == 4'd0) begin
            nxt = 4'd10; tag = "R3";
        end else if (model_st == 4'd12) begin
            nxt = 4'd9; tag = "R4";
        end else if (model_st > 4'd9) begin
            nxt = model_st + 4'd1; tag = "R3";
        end else begin
            nxt = model_st - 4'd1; tag = "R2";
        end
        model_st = nxt;
        exp_q.push_back(nxt);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares each result just after the edge that produced it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                check(tag_q.pop_front(), cnt_o, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: cnt_o=%0d expected completion", cnt_o);
        end
        report();
    end

    initial begin
        // R1: reset state
        drive(1, 0, 0, 4'd0);
        drive(1, 1, 0, 4'd0);
        // R2 R3 R4: full loop, then R8 return check
        for (int i = 0; i < 13; i++) drive(0, 1, 0, 4'd0);
        @(posedge clk); #2;
        check("R8", cnt_o, 4'd9);
        for (int i = 0; i < 26; i++) drive(0, 1, 0, 4'd0);
        // R6: hold at several states
        drive(0, 0, 0, 4'd0);
        drive(0, 0, 0, 4'd0);
        for (int i = 0; i < 10; i++) drive(0, 1, 0, 4'd0);
        drive(0, 0, 0, 4'd0);
        drive(0, 0, 0, 4'd0);
        drive(0, 1, 0, 4'd0);
        drive(0, 0, 0, 4'd0);
        // R7: load 0 and 12, then step
        drive(0, 1, 1, 4'd0);
        drive(0, 1, 0, 4'd0);
        drive(0, 0, 1, 4'd12);
        drive(0, 0, 0, 4'd0);
        drive(0, 1, 0, 4'd0);
        // R5: each illegal code, enable high and low
        for (int c = 13; c < 16; c++) begin
            drive(0, 0, 1, 4'(c));
            drive(0, 0, 0, 4'd0);
            drive(0, 1, 1, 4'(c));
            drive(0, 1, 0, 4'd0);
        end
        // R7: load overrides recovery of an illegal state
        drive(0, 1, 1, 4'd14);
        drive(0, 1, 1, 4'd3);
        drive(0, 1, 0, 4'd0);
        // R1: reset wins over load and enable
        drive(1, 1, 1, 4'd5);
        drive(0, 1, 0, 4'd0);
        // R1: reset from an illegal state
        drive(0, 0, 1, 4'd15);
        drive(1, 0, 0, 4'd0);
        drive(0, 1, 0, 4'd0);
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        report();
    end

endmodule